// File: doc/BRIEF.md
# Programmable PLL Divider Chain

This block is the digital counter chain of an integer-N frequency synthesizer. On the RF side, an optional divide-by-two stage feeds a 17-bit programmable down-counter. The counter gives one pulse per divided VCO period. On the crystal side, a power-of-two reference divider turns the crystal clock into the comparison clock and a comparison pulse. The phase comparison stage that follows the chain uses the divided pulse and the comparison pulse.

A reference output carries either the raw crystal clock or the comparison clock. It is meant for driving other synthesizers or demodulators. With the divide-by-two stage bypassed, the tuning step equals the comparison frequency. With the stage enabled, the step doubles.

Each side has its own clock and its own synchronous active-high reset. The divider ratio and prescaler enable belong to the RF domain. The reference select belongs to the crystal domain. Changing the prescaler enable or the reference select restarts the counters it affects, so no short period is produced.

Top module: `pll_div_chain`

## Requirements
- R1: With the prescaler off and a programmed ratio N (17 bits, 2..131071), div_pulse is high for exactly one rf_clk cycle and repeats every N rf_clk cycles.
- R2: With the prescaler on, div_pulse stays one rf_clk cycle wide and repeats every 2*N rf_clk cycles.
- R3: A programmed ratio of 0 or 1 behaves as a ratio of 2.
- R4: A divider ratio written mid-period does not affect the period in progress. It is loaded at the next reload, which is the rf_clk edge that ends the div_pulse cycle.
- R5: ref_sel values 0, 1, 2 and 3 give reference ratios of 2, 4, 8 and 16 crystal cycles. comp_pulse is high for one xtal_clk cycle per reference period.
- R6: The comparison clock is low for the first half of each reference period and high for the second half. comp_pulse falls in the last high cycle.
- R7: When out_sel is 0, ref_out follows xtal_clk. When out_sel is 1, ref_out follows the comparison clock.
- R8: In the rf_clk cycle where pre_en differs from its value at the previous edge, div_pulse is held low. The following edge restarts the prescaler and the main counter, and the next div_pulse arrives one full new period after that edge.
- R9: In the xtal_clk cycle where ref_sel differs from its value at the previous edge, comp_pulse is held low. The following edge restarts the reference counter, and the next comp_pulse arrives one full new reference period after that edge.
- R10: While a domain's reset is high, its pulse output is low. After release, the first pulse arrives one full period after the last reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Crystal clock |
| xtal_rst | input | 1 | Synchronous active-high reset, crystal domain |
| rf_clk | input | 1 | RF (VCO) clock |
| rf_rst | input | 1 | Synchronous active-high reset, RF domain |
| div_ratio | input | 17 | Main divider ratio, clamped to a minimum of 2 |
| pre_en | input | 1 | 1 inserts the divide-by-two prescaler |
| ref_sel | input | 2 | Reference ratio select: ratio = 2^(ref_sel+1) |
| out_sel | input | 1 | 0: crystal clock on ref_out, 1: comparison clock |
| comp_pulse | output | 1 | One crystal-cycle pulse per reference period |
| div_pulse | output | 1 | One RF-cycle pulse per divided period |
| ref_out | output | 1 | Selected reference output clock |

## Verification
Two events can fall in the same RF cycle: the terminal count of the main divider and a flip of the prescaler enable. The bench predicts the cycle of the terminal count from a known reload. It then flips pre_en two nanoseconds after the rising edge that opens that cycle. It expects div_pulse to be low at the following falling edge, and expects the next pulse exactly 2N cycles after the restart edge. The crystal side gets the same treatment: a ref_sel change lands in the cycle of a due comparison pulse, and the bench expects the pulse to be withheld and then a full 16-cycle period.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

    typedef enum logic {
        REF_SRC_XTAL = 1'b0,
        REF_SRC_COMP = 1'b1
    } ref_src_e;

    typedef struct packed {
        logic adv;
        logic restart;
    } pre_step_t;

    // Width of the reference counter: the largest ratio is 2^(2^sel_w)
    function automatic int ref_cnt_width(input int sel_w);
        return 1 << sel_w;
    endfunction

endpackage

// File: rtl/rf_prescaler.sv
module rf_prescaler
    import pll_div_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pre_en,
    output pre_step_t step
);
    logic en_q;
    logic tog_q;

    always_ff @(posedge clk) begin
        en_q <= pre_en;
        if (rst || (pre_en != en_q)) begin
            tog_q <= 1'b0;
        end else if (en_q) begin
            tog_q <= ~tog_q;
        end else begin
            tog_q <= 1'b0;
        end
    end

    always_comb begin
        step.restart = (pre_en != en_q);
        step.adv     = en_q ? tog_q : 1'b1;
    end
endmodule

// File: rtl/main_divider.sv
module main_divider #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         adv,
    input  logic [W-1:0] ratio,
    output logic         pulse
);
    localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] FLOOR = {{(W-2){1'b0}}, 2'b10};

    logic [W-1:0] cnt;
    logic [W-1:0] load_val;
    logic         term;

    always_comb begin
        load_val = (ratio < FLOOR) ? FLOOR : ratio;
        term     = (cnt == ONE);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= load_val;
        end else if (adv) begin
            cnt <= term ? load_val : (cnt - ONE);
        end
    end

    assign pulse = !rst && !restart && adv && term;
endmodule

// File: rtl/ref_divider.sv
module ref_divider
    import pll_div_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse,
    output logic             comp_clk
);
    localparam int CW = ref_cnt_width(SEL_W);
    localparam logic [CW-1:0] INC = {{(CW-1){1'b0}}, 1'b1};

    logic [SEL_W-1:0] sel_q;
    logic [CW-1:0]    cnt;
    logic [CW-1:0]    mask;
    logic             restart;

    for (genvar i = 0; i < CW; i++) begin : g_mask
        localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
        assign mask[i] = (IDX <= sel_q);
    end

    assign restart = (sel != sel_q);

    always_ff @(posedge clk) begin
        sel_q <= sel;
        if (rst || restart) begin
            cnt <= '0;
        end else begin
            cnt <= (cnt + INC) & mask;
        end
    end

    assign pulse    = !rst && !restart && ((cnt & mask) == mask);
    assign comp_clk = !rst && cnt[sel_q];
endmodule

// File: rtl/ref_out_mux.sv
module ref_out_mux
    import pll_div_pkg::*;
(
    input  logic     xtal_clk,
    input  logic     comp_clk,
    input  ref_src_e src,
    output logic     ref_out
);
    assign ref_out = (src == REF_SRC_COMP) ? comp_clk : xtal_clk;
endmodule

// File: rtl/pll_div_chain.sv
module pll_div_chain
    import pll_div_pkg::*;
#(
    parameter int MAIN_W    = 17,
    parameter int REF_SEL_W = 2
) (
    input  logic                 xtal_clk,
    input  logic                 xtal_rst,
    input  logic                 rf_clk,
    input  logic                 rf_rst,
    input  logic [MAIN_W-1:0]    div_ratio,
    input  logic                 pre_en,
    input  logic [REF_SEL_W-1:0] ref_sel,
    input  logic                 out_sel,
    output logic                 comp_pulse,
    output logic                 div_pulse,
    output logic                 ref_out
);
    pre_step_t step;
    logic      comp_clk;
    ref_src_e  src;

    assign src = ref_src_e'(out_sel);

    rf_prescaler u_pre (
        .clk    (rf_clk),
        .rst    (rf_rst),
        .pre_en (pre_en),
        .step   (step)
    );

    main_divider #(.W(MAIN_W)) u_main (
        .clk     (rf_clk),
        .rst     (rf_rst),
        .restart (step.restart),
        .adv     (step.adv),
        .ratio   (div_ratio),
        .pulse   (div_pulse)
    );

    ref_divider #(.SEL_W(REF_SEL_W)) u_ref (
        .clk      (xtal_clk),
        .rst      (xtal_rst),
        .sel      (ref_sel),
        .pulse    (comp_pulse),
        .comp_clk (comp_clk)
    );

    ref_out_mux u_mux (
        .xtal_clk (xtal_clk),
        .comp_clk (comp_clk),
        .src      (src),
        .ref_out  (ref_out)
    );
endmodule

// File: rtl/pll_div_chain_chk.sv
module pll_div_chain_chk #(
    parameter int SEL_W = 2
) (
    input logic             xtal_clk,
    input logic             xtal_rst,
    input logic             rf_clk,
    input logic             rf_rst,
    input logic             pre_en,
    input logic [SEL_W-1:0] ref_sel,
    input logic             comp_pulse,
    input logic             div_pulse
);
    // R1, R2: divided pulse is a single RF cycle wide
    a_r1_div_single: assert property (@(posedge rf_clk) disable iff (rf_rst)
        div_pulse |=> !div_pulse);

    // R5: comparison pulse is a single crystal cycle wide
    a_r5_comp_single: assert property (@(posedge xtal_clk) disable iff (xtal_rst)
        comp_pulse |=> !comp_pulse);

    // R8: no divided pulse in the cycle of a prescaler change
    a_r8_pre_change_quiet: assert property (@(posedge rf_clk) disable iff (rf_rst)
        (pre_en != $past(pre_en)) |-> !div_pulse);

    // R9: no comparison pulse in the cycle of a reference select change
    a_r9_sel_change_quiet: assert property (@(posedge xtal_clk) disable iff (xtal_rst)
        (ref_sel != $past(ref_sel)) |-> !comp_pulse);

    // R10: pulses stay low during reset
    a_r10_rf_reset_quiet: assert property (@(posedge rf_clk)
        rf_rst |-> !div_pulse);
    a_r10_xtal_reset_quiet: assert property (@(posedge xtal_clk)
        xtal_rst |-> !comp_pulse);
endmodule

bind pll_div_chain pll_div_chain_chk #(.SEL_W(REF_SEL_W)) u_chk (
    .xtal_clk   (xtal_clk),
    .xtal_rst   (xtal_rst),
    .rf_clk     (rf_clk),
    .rf_rst     (rf_rst),
    .pre_en     (pre_en),
    .ref_sel    (ref_sel),
    .comp_pulse (comp_pulse),
    .div_pulse  (div_pulse)
);

// File: tb/tb_pll_div_chain.sv
`timescale 1ns/1ps
module tb_pll_div_chain;
    logic        xtal_clk = 1'b0;
    logic        rf_clk   = 1'b0;
    logic        xtal_rst = 1'b1;
    logic        rf_rst   = 1'b1;
    logic [16:0] div_ratio = 17'd5;
    logic        pre_en   = 1'b0;
    logic [1:0]  ref_sel  = 2'd1;
    logic        out_sel  = 1'b0;
    logic        comp_pulse, div_pulse, ref_out;

    int checks = 0;
    int fails  = 0;
    int n;

    always #5  rf_clk   = ~rf_clk;
    always #20 xtal_clk = ~xtal_clk;

    pll_div_chain dut (
        .xtal_clk(xtal_clk), .xtal_rst(xtal_rst), .rf_clk(rf_clk), .rf_rst(rf_rst),
        .div_ratio(div_ratio), .pre_en(pre_en), .ref_sel(ref_sel), .out_sel(out_sel),
        .comp_pulse(comp_pulse), .div_pulse(div_pulse), .ref_out(ref_out)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // counts falling rf edges up to and including the next div_pulse
    task automatic wait_div(output int cnt);
        cnt = 0;
        while (1) begin
            @(negedge rf_clk);
            cnt++;
            if (div_pulse || cnt >= 140000) break;
        end
    endtask

    task automatic wait_comp(output int cnt);
        cnt = 0;
        while (1) begin
            @(negedge xtal_clk);
            cnt++;
            if (comp_pulse || cnt >= 1000) break;
        end
    endtask

    task automatic t_reset;
        repeat (4) @(negedge rf_clk);
        check(div_pulse == 1'b0, "R10 div quiet in reset", div_pulse, 0);
        check(comp_pulse == 1'b0, "R10 comp quiet in reset", comp_pulse, 0);
        @(negedge rf_clk) rf_rst = 1'b0;
        wait_div(n);
        check(n == 4, "R10 first div pulse after reset", n, 4);
        @(negedge xtal_clk) xtal_rst = 1'b0;
        wait_comp(n);
        check(n == 3, "R10 first comp pulse after reset", n, 3);
    endtask

    task automatic t_main_ratios;
        div_ratio = 17'd7; wait_div(n);
        check(n == 7, "R1 ratio 7", n, 7);
        div_ratio = 17'd3; wait_div(n);
        check(n == 3, "R1 ratio 3", n, 3);
        wait_div(n);
        check(n == 3, "R1 ratio 3 repeat", n, 3);
        div_ratio = 17'd65537; wait_div(n);
        check(n == 65537, "R1 ratio 65537 (bit 16)", n, 65537);
    endtask

    task automatic t_clamp;
        div_ratio = 17'd0; wait_div(n);
        check(n == 2, "R3 ratio 0 clamped", n, 2);
        div_ratio = 17'd1; wait_div(n);
        check(n == 2, "R3 ratio 1 clamped", n, 2);
    endtask

    task automatic t_defer;
        div_ratio = 17'd6; wait_div(n);
        check(n == 6, "R4 ratio 6", n, 6);
        @(negedge rf_clk) div_ratio = 17'd9;
        wait_div(n);
        check(n == 5, "R4 current period keeps old ratio", n, 5);
        wait_div(n);
        check(n == 9, "R4 new ratio after reload", n, 9);
    endtask

    task automatic t_prescale;
        pre_en = 1'b1; wait_div(n);
        check(n == 18, "R8 restart with prescaler on", n, 18);
        wait_div(n);
        check(n == 18, "R2 prescaled period 2N", n, 18);
        div_ratio = 17'd2; wait_div(n);
        check(n == 4, "R2 prescaled ratio 2", n, 4);
        pre_en = 1'b0; div_ratio = 17'd5; wait_div(n);
        check(n == 5, "R8 restart with prescaler off", n, 5);
    endtask

    task automatic t_collide;
        repeat (5) @(posedge rf_clk);
        #2 pre_en = 1'b1;
        @(negedge rf_clk);
        check(div_pulse == 1'b0, "R8 terminal pulse withheld on change", div_pulse, 0);
        wait_div(n);
        check(n == 10, "R8 full period after collision", n, 10);
        pre_en = 1'b0; wait_div(n);
        check(n == 5, "R8 back to unprescaled", n, 5);
    endtask

    task automatic t_ref_ratios;
        for (int s = 0; s < 4; s++) begin
            ref_sel = 2'(s);
            wait_comp(n);
            check(n == (2 << s), "R9 restart on select change", n, 2 << s);
            wait_comp(n);
            check(n == (2 << s), "R5 reference ratio", n, 2 << s);
        end
    endtask

    task automatic t_duty;
        bit good = 1'b1;
        ref_sel = 2'd2; wait_comp(n); wait_comp(n);
        out_sel = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge xtal_clk); #5;
            if (ref_out != ((k - 1) >= 4)) good = 1'b0;
        end
        check(good, "R6 R7 comparison clock on ref_out", ref_out, 1);
        check(comp_pulse == 1'b1, "R6 pulse in last high cycle", comp_pulse, 1);
    endtask

    task automatic t_xtal_out;
        out_sel = 1'b0;
        @(posedge xtal_clk); #5;
        check(ref_out == 1'b1, "R7 crystal high on ref_out", ref_out, 1);
        @(negedge xtal_clk); #5;
        check(ref_out == 1'b0, "R7 crystal low on ref_out", ref_out, 0);
    endtask

    task automatic t_ref_collide;
        ref_sel = 2'd1; wait_comp(n); wait_comp(n);
        repeat (4) @(posedge xtal_clk);
        #2 ref_sel = 2'd3;
        @(negedge xtal_clk);
        check(comp_pulse == 1'b0, "R9 comp pulse withheld on change", comp_pulse, 0);
        wait_comp(n);
        check(n == 16, "R9 full period after collision", n, 16);
    endtask

    initial begin
        repeat (190000) @(posedge rf_clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_main_ratios();
        t_clamp();
        t_defer();
        t_prescale();
        t_collide();
        t_ref_ratios();
        t_duty();
        t_xtal_out();
        t_ref_collide();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule